// File: doc/BRIEF.md
# Coherency-Locked Sample Result Register

This block holds the latest result of a data converter in a 32-bit register that a processor or a transfer engine reads over a narrow bus. The bus can only move one byte or one 16-bit half at a time, so a full result needs at least two accesses. Nothing stops the converter from delivering a fresh sample between those accesses, and the reader could then combine halves of two different samples. Each incoming sample of `RES_W` bits (8 to 20) is stored right-aligned. All bits above it are filled with copies of the sample's top bit, so the highest byte always acts as a sign byte.

Consistency comes from a lock. Any read that does not touch the selected key byte freezes the visible register. A read that touches the key byte releases it. Software sets the key to the byte it reads last. A reader that takes the lower half and then the upper half sets the key to byte 2 or 3, and the lock then spans both accesses. A sample that arrives while the register is frozen is kept in a single holding slot, where a later sample replaces an earlier one. That held sample becomes visible as soon as the lock is released. A one-cycle `eoc` pulse marks every cycle in which a new value has just become visible.

Top module: `sample_lock_reg`

## Requirements
- R1: After reset the visible register is zero, `eoc` is low and the register is unlocked, so every read returns zero.
- R2: A sample presented with `samp_valid` while the register is unlocked and no locking read is under way becomes visible on the next cycle. It is right-aligned in bits `RES_W-1:0`, and bits 31 down to `RES_W` all equal bit `RES_W-1` of the sample.
- R3: `eoc` is high for exactly the cycles in which the visible register has just taken a new sample, and it is low otherwise.
- R4: A byte read (`rd_wide`=0) returns `{8'h00, byte[rd_addr]}` on `rd_data` in the same cycle. Byte k covers bits 8k+7 down to 8k.
- R5: A 16-bit read (`rd_wide`=1) ignores `rd_addr[0]` and returns `{byte[2w+1], byte[2w]}`, where w is `rd_addr[1]`.
- R6: A read that does not cover the key byte locks the register. While the register is locked, the visible value does not change.
- R7: A read that covers the key byte leaves the register unlocked afterwards. This includes a 16-bit read that covers the key byte on its first access.
- R8: A sample that arrives while the register is locked is held. A later held sample replaces an earlier one. The held sample becomes visible two cycles after the unlocking read, and `eoc` pulses in that same cycle.
- R9: `key_sel` value k makes byte k the key byte, for k from 0 to 3.
- R10: A sample that arrives in the same cycle as a locking read is held and is not made visible.
- R11: If a new sample arrives in the first cycle that allows a commit, and a held sample is also waiting, the new sample is made visible and the held sample is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | A new converter sample is present this cycle |
| samp_data | input | RES_W | Converter sample, two's complement |
| key_sel | input | 2 | Index of the key byte that releases the lock |
| rd_en | input | 1 | A read access takes place this cycle |
| rd_wide | input | 1 | 1 selects a 16-bit read, 0 selects a byte read |
| rd_addr | input | 2 | Byte index of the read |
| rd_data | output | 16 | Read data for the current access |
| eoc | output | 1 | One-cycle pulse when a new sample becomes visible |

## Verification
The collision that matters is a sample arriving in the same cycle as a read. If the read locks the register, the sample must go to the holding slot. If the read covers the key byte, the sample must go to the holding slot when the register was already locked, and must be made visible when it was not. The bench provokes this directly: it presents samples in the same cycle as locking reads, as unlocking reads and as 16-bit reads that cover the key. It also delivers a fresh sample in the cycle right after an unlock, so that it competes with a waiting held sample. A behavioural model judges each of these cycles by comparing `rd_data` and `eoc` with the model on every clock. A long random phase then mixes all of these cases under changing key settings.

// File: rtl/slr_pkg.sv
package slr_pkg;
   localparam int BUS_W   = 16;
   localparam int BYTE_W  = 8;
endpackage

// File: rtl/slr_sext.sv
module slr_sext #(
   parameter int RES_W = 16,
   parameter int OUT_W = 32
) (
   input  logic [RES_W-1:0] din,
   output logic [OUT_W-1:0] dout
);
   generate
      if (OUT_W == RES_W) begin : g_none
         assign dout = din;
      end else begin : g_fill
         localparam int FILL_W = OUT_W - RES_W;
         assign dout = {{FILL_W{din[RES_W-1]}}, din};
      end
   endgenerate
endmodule

// File: rtl/slr_lock.sv
module slr_lock #(
   parameter int NB = 4,
   localparam int AW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          rd_wide,
   input  logic [AW-1:0] rd_addr,
   input  logic [AW-1:0] key_sel,
   output logic          lock_q,
   output logic          hold
);
   logic [NB-1:0] touch;
   logic          key_hit;

   genvar gi;
   generate
      for (gi = 0; gi < NB; gi++) begin : g_touch
         assign touch[gi] = rd_en && (rd_wide ? ((AW'(gi) >> 1) == (rd_addr >> 1))
                                              : (AW'(gi) == rd_addr));
      end
   endgenerate

   assign key_hit = touch[key_sel];
   assign hold    = lock_q || (rd_en && !key_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b0;
      else if (rd_en)  lock_q <= !key_hit;
   end

   // R6
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !key_hit |=> lock_q);
   // R7
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && key_hit |=> !lock_q);
   // R6
   lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(lock_q));
endmodule

// File: rtl/slr_store.sv
module slr_store #(
   parameter int OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             samp_valid,
   input  logic [OUT_W-1:0] samp_ext,
   output logic [OUT_W-1:0] vis_q,
   output logic             eoc_q
);
   logic [OUT_W-1:0] shd_q;
   logic             shv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_q <= '0;
         shd_q <= '0;
         shv_q <= 1'b0;
         eoc_q <= 1'b0;
      end else if (!hold && (samp_valid || shv_q)) begin
         vis_q <= samp_valid ? samp_ext : shd_q;
         shv_q <= 1'b0;
         eoc_q <= 1'b1;
      end else begin
         eoc_q <= 1'b0;
         if (samp_valid) begin
            shd_q <= samp_ext;
            shv_q <= 1'b1;
         end
      end
   end

   // R6
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(vis_q));
   // R2
   direct_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold && samp_valid |=> eoc_q && (vis_q == $past(samp_ext)));
   // R8
   held_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold && shv_q && !samp_valid |=> eoc_q && !shv_q);
   // R3
   no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_valid && !shv_q |=> !eoc_q);
endmodule

// File: rtl/slr_rdmux.sv
module slr_rdmux #(
   parameter int OUT_W = 32,
   localparam int NB = OUT_W / slr_pkg::BYTE_W,
   localparam int AW = $clog2(NB)
) (
   input  logic [OUT_W-1:0]         vis,
   input  logic                     rd_wide,
   input  logic [AW-1:0]            rd_addr,
   output logic [slr_pkg::BUS_W-1:0] rd_data
);
   localparam int NW = NB / 2;
   logic [slr_pkg::BYTE_W-1:0] bytes [NB];
   logic [slr_pkg::BUS_W-1:0]  words [NW];

   genvar gb;
   generate
      for (gb = 0; gb < NB; gb++) begin : g_byte
         assign bytes[gb] = vis[gb*slr_pkg::BYTE_W +: slr_pkg::BYTE_W];
      end
      for (gb = 0; gb < NW; gb++) begin : g_word
         assign words[gb] = {bytes[2*gb+1], bytes[2*gb]};
      end
   endgenerate

   always_comb begin
      if (rd_wide) rd_data = words[rd_addr >> 1];
      else         rd_data = {8'h00, bytes[rd_addr]};
   end
endmodule

// File: rtl/sample_lock_reg.sv
module sample_lock_reg #(
   parameter int RES_W = 16,
   parameter int OUT_W = 32,
   localparam int NB = OUT_W / slr_pkg::BYTE_W,
   localparam int AW = $clog2(NB)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      samp_valid,
   input  logic [RES_W-1:0]          samp_data,
   input  logic [AW-1:0]             key_sel,
   input  logic                      rd_en,
   input  logic                      rd_wide,
   input  logic [AW-1:0]             rd_addr,
   output logic [slr_pkg::BUS_W-1:0] rd_data,
   output logic                      eoc
);
   generate
      if (RES_W < 8 || RES_W > 20) begin : g_bad_res
         $error("sample_lock_reg: RES_W must lie in 8..20");
      end
      if (OUT_W % slr_pkg::BUS_W != 0 || OUT_W < RES_W + slr_pkg::BYTE_W) begin : g_bad_out
         $error("sample_lock_reg: OUT_W must be a multiple of 16 with a full sign byte");
      end
   endgenerate

   logic [OUT_W-1:0] samp_ext;
   logic [OUT_W-1:0] vis_q;
   logic             lock_q;
   logic             hold;

   slr_sext #(.RES_W(RES_W), .OUT_W(OUT_W)) u_sext (
      .din (samp_data),
      .dout(samp_ext)
   );

   slr_lock #(.NB(NB)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_wide(rd_wide),
      .rd_addr(rd_addr),
      .key_sel(key_sel),
      .lock_q (lock_q),
      .hold   (hold)
   );

   slr_store #(.OUT_W(OUT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .samp_valid(samp_valid),
      .samp_ext  (samp_ext),
      .vis_q     (vis_q),
      .eoc_q     (eoc)
   );

   slr_rdmux #(.OUT_W(OUT_W)) u_rdmux (
      .vis    (vis_q),
      .rd_wide(rd_wide),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   // R2
   sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&vis_q[OUT_W-1:RES_W-1]) || !(|vis_q[OUT_W-1:RES_W-1]));
   // R10
   same_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q && rd_en && hold && samp_valid |=> !eoc && lock_q);
endmodule

// File: tb/tb_sample_lock_reg.sv
module tb_sample_lock_reg;
   localparam int RES = 12;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        samp_valid = 0;
   logic [RES-1:0] samp_data = '0;
   logic [1:0]  key_sel = 0;
   logic        rd_en = 0;
   logic        rd_wide = 0;
   logic [1:0]  rd_addr = 0;
   logic [15:0] rd_data;
   logic        eoc;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   int cycles = 0;

   logic [31:0] m_vis = 0;
   logic [31:0] m_sh = 0;
   bit          m_shv = 0, m_lock = 0, m_eoc = 0;

   always #5 clk = ~clk;

   sample_lock_reg #(.RES_W(RES)) dut (
      .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
      .key_sel(key_sel), .rd_en(rd_en), .rd_wide(rd_wide), .rd_addr(rd_addr),
      .rd_data(rd_data), .eoc(eoc)
   );

   function automatic logic [31:0] ext(logic [RES-1:0] d);
      logic signed [31:0] t;
      t = $signed({d, {(32-RES){1'b0}}});
      return 32'(t >>> (32 - RES));
   endfunction

   function automatic logic [15:0] exp_rd();
      int w;
      if (rd_wide) begin
         w = int'(rd_addr) / 2;
         return m_vis[16*w +: 16];
      end
      return {8'h00, m_vis[8*int'(rd_addr) +: 8]};
   endfunction

   function automatic bit covers_key();
      if (!rd_en) return 0;
      if (rd_wide) return (key_sel >> 1) == (rd_addr >> 1);
      return key_sel == rd_addr;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_vis = 0; m_sh = 0; m_shv = 0; m_lock = 0; m_eoc = 0;
      end else begin
         bit cov, blocked;
         cov = covers_key();
         blocked = m_lock || (rd_en && !cov);
         if (!blocked && (samp_valid || m_shv)) begin
            m_vis = samp_valid ? ext(samp_data) : m_sh;
            m_shv = 0; m_eoc = 1;
         end else begin
            m_eoc = 0;
            if (samp_valid) begin m_sh = ext(samp_data); m_shv = 1; end
         end
         if (rd_en) m_lock = !cov;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(bit sv, logic [RES-1:0] sd, bit rd, bit wide, logic [1:0] a);
      @(posedge clk); #1;
      samp_valid = sv; samp_data = sd; rd_en = rd; rd_wide = wide; rd_addr = a;
      @(negedge clk);
      chk({cur_req, " rd_data"}, 32'(rd_data), 32'(exp_rd()));
      chk({cur_req, " eoc"}, 32'(eoc), 32'(m_eoc));
   endtask

   task automatic idle(); cyc(0, '0, 0, 0, 0); endtask

   initial begin
      repeat (3) @(posedge clk);
      // R1 reset state at the ports
      for (int a = 0; a < 4; a++) begin
         rd_addr = 2'(a);
         #1 chk("R1 byte after reset", 32'(rd_data), 32'h0);
      end
      chk("R1 eoc after reset", 32'(eoc), 32'h0);
      @(negedge clk); rst_n = 1;

      // R2 R3 R4 R5 commit, sign fill, byte and word reads
      cur_req = "R2";
      key_sel = 0;
      cyc(1, 12'h823, 0, 0, 0);
      cyc(0, '0, 0, 0, 1);
      chk("R3 eoc pulse on commit", 32'(eoc), 32'h1);
      chk("R2 R4 byte1 sign fill", 32'(rd_data), 32'h00F8);
      cur_req = "R5";
      cyc(0, '0, 0, 1, 3);
      chk("R5 upper word sign fill", 32'(rd_data), 32'hFFFF);
      chk("R3 eoc single cycle", 32'(eoc), 32'h0);
      cyc(0, '0, 0, 1, 1);
      chk("R5 lower word addr bit0 ignored", 32'(rd_data), 32'hF823);
      cyc(1, 12'h345, 0, 0, 0);
      cyc(0, '0, 0, 1, 2);
      chk("R2 positive sample upper word", 32'(rd_data), 32'h0000);

      // R6 R8 R9 lock with key in upper word, samples held, last wins
      cur_req = "R6";
      key_sel = 3;
      cyc(0, '0, 1, 1, 0);
      cyc(1, 12'h111, 0, 0, 0);
      cyc(1, 12'h7AB, 0, 0, 0);
      cyc(0, '0, 0, 1, 0);
      chk("R6 value frozen while locked", 32'(rd_data), 32'h0345);
      cur_req = "R8";
      cyc(0, '0, 1, 1, 2);
      cyc(0, '0, 0, 0, 0);
      chk("R8 no commit one cycle after unlock", 32'(eoc), 32'h0);
      cyc(0, '0, 0, 1, 0);
      chk("R8 held sample visible", 32'(rd_data), 32'h07AB);
      chk("R8 eoc on held commit", 32'(eoc), 32'h1);

      // R10 sample in same cycle as locking read
      cur_req = "R10";
      key_sel = 2;
      cyc(1, 12'h0F0, 1, 0, 0);
      cyc(0, '0, 0, 0, 0);
      chk("R10 no eoc", 32'(eoc), 32'h0);
      chk("R10 old byte0 kept", 32'(rd_data), 32'h00AB);
      cyc(0, '0, 1, 0, 2);
      idle(); idle();

      // R7 wide read covering key on first access
      cur_req = "R7";
      key_sel = 1;
      cyc(0, '0, 1, 1, 0);
      cyc(1, 12'h456, 0, 0, 0);
      cyc(0, '0, 0, 1, 0);
      chk("R7 commit after covering wide read", 32'(rd_data), 32'h0456);

      // R11 fresh sample against held sample
      cur_req = "R11";
      key_sel = 0;
      cyc(0, '0, 1, 0, 1);
      cyc(1, 12'h222, 0, 0, 0);
      cyc(0, '0, 1, 0, 0);
      cyc(1, 12'h999, 0, 0, 0);
      cyc(0, '0, 0, 1, 0);
      chk("R11 fresh sample wins", 32'(rd_data), 32'hF999);
      idle();
      chk("R11 held sample discarded", 32'(eoc), 32'h0);

      // R9 each key position in turn with byte reads
      cur_req = "R9";
      for (int k = 0; k < 4; k++) begin
         key_sel = 2'(k);
         cyc(0, '0, 1, 0, 2'(k + 1));
         cyc(1, 12'(k * 37 + 5), 0, 0, 0);
         cyc(0, '0, 1, 0, 2'(k));
         idle(); idle();
      end

      // random mix judged by the model
      cur_req = "R2 R6 R7 R8 R10 R11 random";
      for (int i = 0; i < 400; i++) begin
         if (i % 50 == 0) key_sel = 2'($urandom);
         cyc(1'($urandom % 3 == 0), RES'($urandom), 1'($urandom % 2), 1'($urandom),
             2'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule